// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog that software must service on a schedule. A 16-bit timeout value counts down once for each prescaled tick. The prescaled tick comes from a slow reference tick input, nominally 32 kHz, divided by a power of two that software selects. Writing the timeout register loads the counter and starts the first stage. If software does not rewrite it in time, the first stage expires, the counter reloads, and a second stage begins. If the second stage also expires, a second action fires.

Each stage has its own action, coded in two bits: 00 does nothing, 01 raises an interrupt, 10 raises a system-management interrupt and 11 requests a system reset. Sticky status flags record the expiry and every action that fired. The interrupt and SMI outputs follow their flags. The reset request is a one-cycle pulse. Three registers sit behind a simple write-strobe bus with a combinational read port. With a prescaler exponent of 13 and a timeout of 65535, the longest interval at 32000 ticks per second is 2^13 × 65535 / 32000 seconds.

Top module: `wdt_two_stage`

## Requirements
- R1: After a synchronous reset, every register reads 0 (both actions are 00) and `irq`, `smi` and `rst_req` are low.
- R2: The timeout register is at offset 0x0 and the configuration register at 0x2. Both read back exactly what was written (configuration bits [15:9] are spare storage), except for the clamp in R3. The status register is at offset 0x4 and its bits [7:4] and [15:8] always read 0.
- R3: Configuration bits [3:0] hold the prescaler exponent p. A write of 0xE or 0xF stores 0xD.
- R4: After a write of a nonzero value N to the timeout register, the first expiry sets status bit 0 (overflow). It occurs on reference tick N × 2^p, counted from that write, and not before.
- R5: At an expiry, the stage's action sets a status flag: 01 sets bit 1 and `irq`, 10 sets bit 2 and `smi`, 11 sets bit 3 and gives a `rst_req` pulse exactly one clock wide. 00 sets only bit 0. `irq` and `smi` stay high while their flags are set.
- R6: The first expiry reloads N and starts the second stage. The second stage expires after a further N × 2^p ticks and applies the action in configuration bits [7:6]. The first stage uses bits [5:4].
- R7: Any write to the timeout register restarts the first stage and the prescaler. Ticks counted before the write do not count toward the next expiry.
- R8: Writing 0 to the timeout register stops the watchdog: no further expiry occurs.
- R9: While configuration bit 8 is 1, reference ticks are ignored and the countdown does not advance.
- R10: Writing the status register with bit 0 set clears all four flags. A write with bit 0 clear changes nothing.
- R11: After the second expiry the watchdog stays idle and raises no further events until the timeout register is written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle pulse per slow reference period |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Interrupt, high while status bit 1 is set |
| smi | output | 1 | System-management interrupt, high while status bit 2 is set |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
An expiry is caused by a reference tick sampled at clock edge k. The stage counter registers the event at edge k, and the status flags, `irq`, `smi` and `rst_req` change at edge k+1. Register writes take effect at the edge that samples the strobe, and reads are combinational. The bench therefore drives each tick as a one-cycle pulse and waits three more clocks before it reads status or samples outputs, always on the falling edge. Expiry timing is checked by reading status one tick before the expected interval ends and again at the last tick. The reset-request width is checked by a falling-edge monitor that counts high cycles and back-to-back highs.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int TMO_W    = 16;
    localparam int ADDR_W   = 3;
    localparam int PRES_W   = 4;
    localparam int PRES_MAX = 13;
    localparam int PCNT_W   = PRES_MAX;

    localparam logic [ADDR_W-1:0] OFS_TMO = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_CFG = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_STS = 3'd4;

    typedef enum logic [1:0] {
        ACT_NONE = 2'b00,
        ACT_IRQ  = 2'b01,
        ACT_SMI  = 2'b10,
        ACT_RST  = 2'b11
    } act_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2
    } stage_e;

    // Field order is fixed by the register layout (MSB first).
    typedef struct packed {
        logic [6:0]        spare;
        logic              ref_off;
        act_e              act2;
        act_e              act1;
        logic [PRES_W-1:0] pres;
    } cfg_t;

    typedef struct packed {
        logic rst;
        logic smi;
        logic irq;
        logic ovf;
    } sts_t;

    typedef struct packed {
        logic valid;
        logic second;
    } expiry_t;

    function automatic cfg_t cfg_sanitize(input logic [TMO_W-1:0] w);
        cfg_t c;
        c = cfg_t'(w);
        if (c.pres > PRES_W'(PRES_MAX))
            c.pres = PRES_W'(PRES_MAX);
        return c;
    endfunction

    function automatic sts_t sts_apply(input sts_t s, input act_e a);
        sts_t r;
        r = s;
        r.ovf = 1'b1;
        case (a)
            ACT_IRQ: r.irq = 1'b1;
            ACT_SMI: r.smi = 1'b1;
            ACT_RST: r.rst = 1'b1;
            default: ;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
    import wdt_pkg::*;
#(
    parameter int P_W = PRES_W,
    parameter int C_W = PCNT_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           ref_tick,
    input  logic           ref_off,
    input  logic           restart,
    input  logic [P_W-1:0] pres,
    output logic           wd_tick
);

    logic [C_W-1:0] pcnt;
    logic [C_W:0]   lim_wide;
    logic           live_tick;

    assign live_tick = ref_tick && !ref_off;
    assign lim_wide  = ((C_W+1)'(1) << pres) - (C_W+1)'(1);
    assign wd_tick   = live_tick && (pcnt == lim_wide[C_W-1:0]);

    always_ff @(posedge clk) begin
        if (rst || restart)
            pcnt <= '0;
        else if (live_tick)
            pcnt <= wd_tick ? '0 : pcnt + C_W'(1);
    end

    // R9: a gated reference leaves the divider frozen
    a_r9_gate_freezes: assert property (@(posedge clk) disable iff (rst)
        (ref_off && !restart) |=> $stable(pcnt));

endmodule

// File: rtl/wdt_stage_counter.sv
module wdt_stage_counter
    import wdt_pkg::*;
#(
    parameter int W = TMO_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         wd_tick,
    output expiry_t      ev
);

    logic [W-1:0] reload;
    logic [W-1:0] cnt;
    stage_e       stage;

    always_ff @(posedge clk) begin
        if (rst) begin
            reload <= '0;
            cnt    <= '0;
            stage  <= ST_IDLE;
            ev     <= '0;
        end else begin
            ev <= '0;
            if (load) begin
                reload <= load_val;
                cnt    <= load_val;
                stage  <= (load_val == '0) ? ST_IDLE : ST_FIRST;
            end else if (wd_tick && stage != ST_IDLE) begin
                if (cnt == W'(1)) begin
                    ev.valid  <= 1'b1;
                    ev.second <= (stage == ST_SECOND);
                    if (stage == ST_FIRST) begin
                        cnt   <= reload;
                        stage <= ST_SECOND;
                    end else begin
                        cnt   <= '0;
                        stage <= ST_IDLE;
                    end
                end else begin
                    cnt <= cnt - W'(1);
                end
            end
        end
    end

    // R8, R11: an idle counter produces no expiry
    a_r8_idle_silent: assert property (@(posedge clk) disable iff (rst)
        (stage == ST_IDLE && !load) |=> !ev.valid);

    // R6: a second-stage event only comes out of the second stage
    a_r6_second_origin: assert property (@(posedge clk) disable iff (rst)
        (ev.valid && ev.second) |-> $past(stage) == ST_SECOND);

    // R6: a first-stage event leaves the counter in the second stage
    a_r6_first_advances: assert property (@(posedge clk) disable iff (rst)
        (ev.valid && !ev.second) |-> stage == ST_SECOND);

endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int W  = TMO_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    input  expiry_t       ev,
    output logic          tmo_load,
    output cfg_t          cfg,
    output logic [W-1:0]  rdata,
    output logic          irq,
    output logic          smi,
    output logic          rst_req
);

    localparam int STS_PAD = W - $bits(sts_t);

    logic [W-1:0] tmo_q;
    cfg_t         cfg_q;
    sts_t         sts_q;
    sts_t         sts_n;
    logic         rst_req_q;
    logic         sts_clr;
    logic         sts_wr;
    act_e         act_now;

    assign tmo_load = wr_en && (addr == OFS_TMO);
    assign sts_wr   = wr_en && (addr == OFS_STS);
    assign sts_clr  = sts_wr && wdata[0];
    assign act_now  = ev.second ? cfg_q.act2 : cfg_q.act1;

    always_comb begin
        sts_n = sts_q;
        if (sts_clr)
            sts_n = '0;
        if (ev.valid)
            sts_n = sts_apply(sts_n, act_now);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tmo_q     <= '0;
            cfg_q     <= '0;
            sts_q     <= '0;
            rst_req_q <= 1'b0;
        end else begin
            if (tmo_load)
                tmo_q <= wdata;
            if (wr_en && addr == OFS_CFG)
                cfg_q <= cfg_sanitize(wdata);
            sts_q     <= sts_n;
            rst_req_q <= ev.valid && (act_now == ACT_RST);
        end
    end

    always_comb begin
        case (addr)
            OFS_TMO: rdata = tmo_q;
            OFS_CFG: rdata = cfg_q;
            OFS_STS: rdata = {{STS_PAD{1'b0}}, sts_q};
            default: rdata = '0;
        endcase
    end

    assign cfg     = cfg_q;
    assign irq     = sts_q.irq;
    assign smi     = sts_q.smi;
    assign rst_req = rst_req_q;

    // R5: reset request never lasts two cycles
    a_r5_rst_single: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);

    // R5: a reset request is always recorded in status
    a_r5_rst_flagged: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> sts_q.rst);

    // R4: every expiry leaves the overflow flag set
    a_r4_ovf_follows: assert property (@(posedge clk) disable iff (rst)
        ev.valid |=> sts_q.ovf);

    // R3: stored prescaler exponent is always legal
    a_r3_pres_legal: assert property (@(posedge clk) disable iff (rst)
        cfg_q.pres <= PRES_W'(PRES_MAX));

    // R10: flags move only on an expiry or a status write
    a_r10_sts_hold: assert property (@(posedge clk) disable iff (rst)
        (!ev.valid && !sts_wr) |=> $stable(sts_q));

endmodule

// File: rtl/wdt_two_stage.sv
module wdt_two_stage
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_tick,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [TMO_W-1:0]  bus_wdata,
    output logic [TMO_W-1:0]  bus_rdata,
    output logic              irq,
    output logic              smi,
    output logic              rst_req
);

    cfg_t    cfg;
    expiry_t ev;
    logic    tmo_load;
    logic    wd_tick;

    wdt_regs #(.W(TMO_W), .AW(ADDR_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .ev       (ev),
        .tmo_load (tmo_load),
        .cfg      (cfg),
        .rdata    (bus_rdata),
        .irq      (irq),
        .smi      (smi),
        .rst_req  (rst_req)
    );

    wdt_prescaler #(.P_W(PRES_W), .C_W(PCNT_W)) u_pres (
        .clk      (clk),
        .rst      (rst),
        .ref_tick (ref_tick),
        .ref_off  (cfg.ref_off),
        .restart  (tmo_load),
        .pres     (cfg.pres),
        .wd_tick  (wd_tick)
    );

    wdt_stage_counter #(.W(TMO_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (tmo_load),
        .load_val (bus_wdata),
        .wd_tick  (wd_tick),
        .ev       (ev)
    );

endmodule

// File: tb/wdt_two_stage_test.sv
module wdt_two_stage_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic        irq, smi, rst_req;

    int n_checks = 0;
    int n_fail   = 0;
    int rst_pulses = 0;
    int rst_wide   = 0;
    logic rst_prev = 1'b0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    wdt_two_stage uut (
        .clk(clk), .rst(rst), .ref_tick(ref_tick),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq), .smi(smi), .rst_req(rst_req)
    );

    always @(negedge clk) begin
        if (rst_req) rst_pulses++;
        if (rst_req && rst_prev) rst_wide++;
        rst_prev = rst_req;
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int v);
        @(negedge clk);
        bus_addr = a;
        #1;
        v = int'(bus_rdata);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ref_tick = 1'b1;
            @(negedge clk); ref_tick = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    function automatic int flag_of(input int act);
        case (act)
            1: return 2;
            2: return 4;
            3: return 8;
            default: return 0;
        endcase
    endfunction

    function automatic int cfg_word(input int a1, input int a2, input int p);
        return (a2 << 6) | (a1 << 4) | p;
    endfunction

    initial begin
        #(4 * 190000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (all requirements) actual=hung expected=complete");
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int v;
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(3'd0, v); check("R1 timeout", v, 0);
        rd(3'd2, v); check("R1 config", v, 0);
        rd(3'd4, v); check("R1 status", v, 0);
        check("R1 outputs", {irq, smi, rst_req}, 0);

        // R2: map and readback
        wr(3'd2, 16'hFE05); rd(3'd2, v); check("R2 config readback", v, 16'hFE05);
        wr(3'd0, 16'h1234); rd(3'd0, v); check("R2 timeout readback", v, 16'h1234);
        wr(3'd0, 16'h0000);
        wr(3'd4, 16'hFFF0); rd(3'd4, v); check("R2 status upper zero", v, 0);

        // R3: clamp
        wr(3'd2, 16'h000E); rd(3'd2, v); check("R3 clamp 0xE", v, 16'h000D);
        wr(3'd2, 16'h001F); rd(3'd2, v); check("R3 clamp 0xF", v, 16'h001D);

        // R9: gated reference
        wr(3'd2, 16'h0110);
        wr(3'd0, 16'd2);
        ticks(6);
        rd(3'd4, v); check("R9 gated no expiry", v, 0);
        wr(3'd2, 16'h0010);
        ticks(2);
        rd(3'd4, v); check("R9 ungated expiry", v, 3);
        wr(3'd0, 16'd0);
        wr(3'd4, 16'h0001);

        // R7: kick restarts (p=1, N=3 -> 6 ticks)
        wr(3'd2, 16'h0011);
        wr(3'd0, 16'd3);
        ticks(5);
        wr(3'd0, 16'd3);
        ticks(5);
        rd(3'd4, v); check("R7 no expiry after kick", v, 0);
        ticks(1);
        rd(3'd4, v); check("R7 expiry after kick", v, 3);
        check("R5 irq high", irq, 1);

        // R10: clear semantics
        wr(3'd4, 16'h00FE); rd(3'd4, v); check("R10 bit0 clear no effect", v, 3);
        wr(3'd4, 16'h0001); rd(3'd4, v); check("R10 clear", v, 0);
        check("R10 irq low", irq, 0);

        // R8: zero stops
        wr(3'd0, 16'd0);
        ticks(20);
        rd(3'd4, v); check("R8 stopped", v, 0);

        // Random two-stage runs: R4 R5 R6 R11
        for (int it = 0; it < 12; it++) begin
            int a1, a2, p, n, e, s1, pulses0;
            a1 = int'($urandom_range(3, 0));
            a2 = int'($urandom_range(3, 0));
            p  = int'($urandom_range(2, 0));
            n  = int'($urandom_range(4, 1));
            if (it == 0) begin a1 = 3; a2 = 3; end
            e  = n << p;
            s1 = 1 | flag_of(a1);
            wr(3'd4, 16'h0001);
            wr(3'd2, 16'(cfg_word(a1, a2, p)));
            pulses0 = rst_pulses;
            wr(3'd0, 16'(n));
            ticks(e - 1);
            rd(3'd4, v); check("R4 not yet expired", v, 0);
            ticks(1);
            rd(3'd4, v); check("R4 R5 first expiry flags", v, s1);
            check("R5 irq level", irq, (s1 >> 1) & 1);
            check("R5 smi level", smi, (s1 >> 2) & 1);
            ticks(e - 1);
            rd(3'd4, v); check("R6 second not yet", v, s1);
            ticks(1);
            rd(3'd4, v); check("R6 second expiry flags", v, s1 | flag_of(a2));
            check("R5 reset pulse count", rst_pulses - pulses0,
                  (a1 == 3 ? 1 : 0) + (a2 == 3 ? 1 : 0));
            check("R5 reset pulse width", rst_wide, 0);
            wr(3'd4, 16'h0001);
            ticks(2 * e);
            rd(3'd4, v); check("R11 idle after second", v, 0);
            wr(3'd0, 16'd0);
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule